// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Controller

This block sits on the host side of a small three-wire serial EEPROM that holds 128 bytes behind a 7-bit address. A client asks for one of three operations: unlock writes, store one byte, or fetch one byte. Each request is a level held on its own line until the block pulses `ack`. The block then frames the command as whole bytes. The start bit and the two opcode bits are packed against the low end of the first two bytes, and the address fills the low seven bits of the second byte. The block shifts the bytes out on a divided serial clock, with an active-high chip select around the whole frame.

For a fetch, the block flips the resting level of the serial clock from high to low before it clocks in the data byte. It presents the byte on `rdData` with a one-cycle `rdValid` strobe. Dropping chip select after an unlock or a store starts the memory's internal programming cycle. The block then raises `busy` for a fixed, parameterised number of system cycles and accepts nothing new until that time has passed. The first store after reset is preceded by an unlock frame that the block issues on its own.

Top module: `eeprom_wire_ctrl`

## Requirements
- R1: Chip select is high only while a frame is shifted. An unlock frame carries 16 bits and a store or fetch frame carries 24 bits, all MSB first.
- R2: The first command byte is six zeros, the start bit (1) and the opcode MSB. The second byte is the opcode LSB followed by address bits 6..0. The opcodes are unlock 00, store 01, fetch 10.
- R3: An unlock frame is the bytes 0x02 then 0x60.
- R4: A store frame is 0x02, then the address with bit 7 set, then the data byte.
- R5: A fetch frame is 0x03, then the address with bit 7 clear, then 0x00. The eight bits sampled on `miso` during the third byte, MSB first, appear on `rdData`. `rdValid` pulses high for one cycle, in the first cycle chip select is low.
- R6: The serial clock rests high during command and store bytes and whenever chip select is low. It rests low during the fetch data byte and returns high in the cycle chip select drops.
- R7: After an unlock or store frame, `busy` is high for exactly WAIT_CYC = (CLK_HZ/1e6)*WAIT_US cycles, starting in the cycle chip select drops. No `ack` and no chip-select rise occurs while `busy` is high. A fetch frame raises no `busy`.
- R8: The first store request after reset first causes an unlock frame that is not acknowledged. After the wait, the store is acknowledged and sent. Later stores produce no extra unlock frame.
- R9: When several requests are pending, fetch is served first, then store, then unlock.
- R10: `ack` is a one-cycle pulse. Chip select rises in the next cycle.
- R11: Each byte is 8 clock pulses whose halves last HALF_DIV cycles each, with one idle cycle between bytes. A frame of n bytes therefore keeps chip select high for n*(16*HALF_DIV+1) cycles. `mosi` holds steady while the clock is at its active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReq | input | 1 | Fetch request, held until ack |
| wrReq | input | 1 | Store request, held until ack |
| enReq | input | 1 | Unlock request, held until ack |
| addr | input | 7 | Byte address for fetch or store |
| wrData | input | 8 | Byte to store |
| ack | output | 1 | One-cycle request acceptance |
| busy | output | 1 | Programming wait in progress |
| rdData | output | 8 | Last fetched byte |
| rdValid | output | 1 | One-cycle strobe for rdData |
| cs | output | 1 | Memory chip select, active high |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory |

## Verification
`ack` is due one cycle after the request is seen in an idle, non-busy state, and chip select rises one cycle after that. Chip select then stays high for exactly n*(16*HALF_DIV+1) cycles. `rdValid`, the new `rdData` and the rise of `busy` all land in the first cycle chip select is low, and `busy` then lasts exactly WAIT_CYC cycles. The bench samples every output on the falling system-clock edge. It logs the frame at the cycle chip select is first seen low. It counts cs-high and busy-high cycles per frame against those formulas. A memory model answers on `miso` from its own bit counts.

// File: rtl/eeprom_wire_pkg.sv
package eeprom_wire_pkg;
  typedef enum logic [1:0] {KIND_EN, KIND_WR, KIND_RD} cmdKind_t;
  typedef enum logic [1:0] {SEL_HEAD, SEL_ADDR, SEL_DATA} byteSel_t;

  // strobes from the sequencer to the shift path
  typedef struct packed {
    logic      capture;  // latch kind, address and data
    cmdKind_t  kind;
    logic      csOn;
    logic      csOff;
    logic      load;     // start shifting the selected byte
    byteSel_t  sel;
    logic      readPol;  // rest the clock low for the fetch data byte
    logic      takeRx;   // publish the received byte
  } dpStrobe_t;
endpackage

// File: rtl/eeprom_wire_path.sv
module eeprom_wire_path
  import eeprom_wire_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strobe,
  input  logic [6:0] addrIn,
  input  logic [7:0] dataIn,
  input  logic       miso,
  output logic       byteDone,
  output logic       cs,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rdData
);
  localparam int unsigned DIV_W = $clog2(HALF_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  cmdKind_t         kindQ;
  logic [6:0]       addrQ;
  logic [7:0]       dataQ;
  logic             csQ, idleLow, running, phase;
  logic [DIV_W-1:0] divCnt;
  logic [2:0]       bitCnt;
  logic [7:0]       shReg, rxReg, rdDataQ;
  logic [1:0]       opc;
  logic [6:0]       addrField;
  logic [7:0]       txByte;

  always_comb begin
    unique case (kindQ)
      KIND_WR: opc = 2'b01;
      KIND_RD: opc = 2'b10;
      default: opc = 2'b00;
    endcase
    addrField = (kindQ == KIND_EN) ? 7'b1100000 : addrQ;
    unique case (strobe.sel)
      SEL_HEAD: txByte = {6'b000000, 1'b1, opc[1]};
      SEL_ADDR: txByte = {opc[0], addrField};
      default:  txByte = (kindQ == KIND_WR) ? dataQ : 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ <= KIND_EN; addrQ <= '0; dataQ <= '0;
      csQ <= 1'b0; idleLow <= 1'b0; running <= 1'b0; phase <= 1'b0;
      divCnt <= '0; bitCnt <= '0; shReg <= '0; rxReg <= '0; rdDataQ <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (strobe.capture) begin
        kindQ <= strobe.kind; addrQ <= addrIn; dataQ <= dataIn;
      end
      if (strobe.csOn) csQ <= 1'b1;
      if (strobe.readPol) idleLow <= 1'b1;
      if (strobe.csOff) begin
        csQ <= 1'b0; idleLow <= 1'b0;
      end
      if (strobe.takeRx) rdDataQ <= rxReg;
      if (strobe.load) begin
        shReg <= txByte; running <= 1'b1; phase <= 1'b0;
        divCnt <= '0; bitCnt <= '0;
      end else if (running) begin
        if (divCnt == DIV_LAST) begin
          divCnt <= '0;
          if (!phase) begin
            phase <= 1'b1;                 // leading edge: sample
            rxReg <= {rxReg[6:0], miso};
          end else begin
            phase <= 1'b0;                 // trailing edge: next bit
            if (bitCnt == 3'd7) begin
              running  <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 3'd1;
              shReg  <= {shReg[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  assign cs     = csQ;
  assign sclk   = (~idleLow) ^ (running & phase);
  assign mosi   = shReg[7];
  assign rdData = rdDataQ;

  // R6: clock rests high outside a frame
  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    !csQ |-> sclk);
  // R11: data line steady while the clock sits at its active level
  p_mosi_steady_r11: assert property (@(posedge clk) disable iff (!rstN)
    (running && phase) |-> $stable(mosi));
endmodule

// File: rtl/eeprom_wire_seq.sv
module eeprom_wire_seq
  import eeprom_wire_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 500000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdReq,
  input  logic      wrReq,
  input  logic      enReq,
  input  logic      byteDone,
  output dpStrobe_t strobe,
  output logic      ack,
  output logic      busy,
  output logic      rdValid
);
  localparam int unsigned WAIT_W = $clog2(WAIT_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_SEND} state_t;

  state_t            state;
  cmdKind_t          kindQ, grantKind;
  logic [1:0]        byteIdx;
  logic              enabled, grant, grantAck, lastByte;
  logic [WAIT_W-1:0] waitCnt;

  always_comb begin
    grant     = (state == ST_IDLE) && (waitCnt == '0) && (rdReq || wrReq || enReq);
    grantKind = KIND_EN;
    grantAck  = 1'b1;
    if (rdReq) begin
      grantKind = KIND_RD;
    end else if (wrReq) begin
      grantKind = enabled ? KIND_WR : KIND_EN;  // R8: unlock first
      grantAck  = enabled;
    end
    lastByte = (kindQ == KIND_EN) ? (byteIdx == 2'd1) : (byteIdx == 2'd2);
  end

  always_comb begin
    strobe         = '0;
    strobe.kind    = grantKind;
    strobe.capture = grant;
    strobe.sel     = SEL_HEAD;
    if (state == ST_START) begin
      strobe.csOn = 1'b1;
      strobe.load = 1'b1;
    end else if (state == ST_SEND && byteDone) begin
      if (lastByte) begin
        strobe.csOff  = 1'b1;
        strobe.takeRx = (kindQ == KIND_RD);
      end else begin
        strobe.load    = 1'b1;
        strobe.sel     = byteSel_t'(byteIdx + 2'd1);
        strobe.readPol = (kindQ == KIND_RD) && (byteIdx == 2'd1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; kindQ <= KIND_EN; byteIdx <= '0;
      enabled <= 1'b0; waitCnt <= '0; ack <= 1'b0; rdValid <= 1'b0;
    end else begin
      ack     <= 1'b0;
      rdValid <= 1'b0;
      if (waitCnt != '0) waitCnt <= waitCnt - WAIT_W'(1);
      unique case (state)
        ST_IDLE: if (grant) begin
          kindQ <= grantKind;
          ack   <= grantAck;
          state <= ST_START;
        end
        ST_START: begin
          byteIdx <= '0;
          state   <= ST_SEND;
        end
        default: if (byteDone) begin
          if (lastByte) begin
            state   <= ST_IDLE;
            rdValid <= (kindQ == KIND_RD);
            if (kindQ != KIND_RD) waitCnt <= WAIT_W'(WAIT_CYC);
            if (kindQ == KIND_EN) enabled <= 1'b1;
          end else begin
            byteIdx <= byteIdx + 2'd1;
          end
        end
      endcase
    end
  end

  assign busy = (waitCnt != '0);

  // R7: nothing is accepted during the programming wait
  p_no_ack_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> !busy);
  // R5: read strobe lasts one cycle
  p_rdvalid_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);
endmodule

// File: rtl/eeprom_wire_ctrl.sv
module eeprom_wire_ctrl
  import eeprom_wire_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned WAIT_US  = 5000,
  parameter int unsigned HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdReq,
  input  logic       wrReq,
  input  logic       enReq,
  input  logic [6:0] addr,
  input  logic [7:0] wrData,
  output logic       ack,
  output logic       busy,
  output logic [7:0] rdData,
  output logic       rdValid,
  output logic       cs,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int unsigned WAIT_CYC = (CLK_HZ / 1_000_000) * WAIT_US;

  dpStrobe_t strobe;
  logic      byteDone;

  eeprom_wire_seq #(.WAIT_CYC(WAIT_CYC)) seqInst (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq), .enReq(enReq),
    .byteDone(byteDone), .strobe(strobe), .ack(ack), .busy(busy),
    .rdValid(rdValid)
  );

  eeprom_wire_path #(.HALF_DIV(HALF_DIV)) pathInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrIn(addr), .dataIn(wrData),
    .miso(miso), .byteDone(byteDone), .cs(cs), .sclk(sclk), .mosi(mosi),
    .rdData(rdData)
  );

  // R10: acceptance pulse followed by chip select
  p_ack_then_cs_r10: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> (cs && !ack));
  // R7: no frame starts during the wait
  p_no_cs_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cs) |-> !busy);
endmodule

// File: tb/eeprom_wire_ctrl_test.sv
module eeprom_wire_ctrl_test;
  localparam int CLK_HZ = 250_000_000;
  localparam int WAIT_US = 2;
  localparam int HALF = 2;
  localparam int WAITC = (CLK_HZ / 1_000_000) * WAIT_US;

  logic clk = 1'b0, rstN = 1'b0;
  logic rdReq = 0, wrReq = 0, enReq = 0, miso = 0;
  logic [6:0] addr = '0;
  logic [7:0] wrData = '0;
  logic ack, busy, rdValid, cs, sclk, mosi;
  logic [7:0] rdData;

  always #2 clk = ~clk;

  eeprom_wire_ctrl #(.CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US), .HALF_DIV(HALF)) uut (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .wrReq(wrReq), .enReq(enReq),
    .addr(addr), .wrData(wrData), .ack(ack), .busy(busy), .rdData(rdData),
    .rdValid(rdValid), .cs(cs), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int vecs = 0, errs = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] devMem [128];
  bit devEn = 0;
  int bitCnt = 0, rdK = 0;
  logic [31:0] bits = '0;
  bit rdPh = 0;
  logic [6:0] rdAddr = '0;

  initial for (int i = 0; i < 128; i++) devMem[i] = 8'h00;

  always @(posedge cs) begin
    bitCnt = 0; bits = '0; rdPh = 0; rdK = 0;
  end

  always @(negedge sclk) if (cs === 1'b1) begin
    if (rdPh) begin
      if (rdK < 8) miso <= devMem[rdAddr][7 - rdK];
      rdK++;
    end else if (bitCnt == 16 && bits[15:8] == 8'h03) begin
      rdPh = 1; rdAddr = bits[6:0];
      miso <= devMem[bits[6:0]][7];
      rdK = 1;
    end else begin
      bits = {bits[30:0], mosi}; bitCnt++;
    end
  end

  always @(posedge sclk) if (cs === 1'b1 && rdPh && bitCnt < 24) begin
    bits = {bits[30:0], mosi}; bitCnt++;
  end

  // ---------------- frame log ----------------
  logic [23:0] fBits [256];
  int fLen [256], busyCnt [256], csCnt [256];
  logic [7:0] fRd [256];
  bit fRdV [256], fBusy [256];
  int nF = 0, curCs = 0;
  bit prevCs = 0;

  always @(negedge clk) if (rstN) begin
    if (!cs && !sclk) chk(0, "R6 clock not resting high with cs low", sclk, 1);
    if (ack && busy) chk(0, "R7 ack during busy", ack, 0);
    if (cs) curCs++;
    if (prevCs && !cs) begin
      fBits[nF] = bits[23:0]; fLen[nF] = bitCnt; fRd[nF] = rdData;
      fRdV[nF] = rdValid; fBusy[nF] = busy; busyCnt[nF] = 0; csCnt[nF] = curCs;
      curCs = 0;
      if (bitCnt == 16 && bits[15:0] == 16'h0260) devEn = 1;
      if (bitCnt == 24 && bits[23:16] == 8'h02 && bits[15] && devEn)
        devMem[bits[14:8]] = bits[7:0];
      nF++;
    end else if (rdValid) begin
      chk(0, "R5 rdValid outside frame end", rdValid, 0);
    end
    if (busy && nF > 0) busyCnt[nF-1]++;
    prevCs = cs;
  end

  // ---------------- expected values ----------------
  logic [7:0] expMem [128];
  bit expEn = 0;
  initial for (int i = 0; i < 128; i++) expMem[i] = 8'h00;

  function automatic logic [23:0] expFrame(int kind, logic [6:0] a, logic [7:0] d);
    if (kind == 0) return 24'h000260;
    if (kind == 1) return {8'h02, 1'b1, a, d};
    return {8'h03, 1'b0, a, 8'h00};
  endfunction

  task automatic checkFrame(int idx, int kind, logic [6:0] a, logic [7:0] d,
                            logic [7:0] expRd);
    int el;
    el = (kind == 0) ? 16 : 24;
    chk(fLen[idx] == el, "R1 frame bit count", fLen[idx], el);
    chk(csCnt[idx] == (el / 8) * (16 * HALF + 1), "R11 cs high duration",
        csCnt[idx], (el / 8) * (16 * HALF + 1));
    if (kind == 0)
      chk(fBits[idx] == expFrame(0, a, d), "R2 R3 unlock frame", fBits[idx], expFrame(0, a, d));
    else if (kind == 1)
      chk(fBits[idx] == expFrame(1, a, d), "R2 R4 store frame", fBits[idx], expFrame(1, a, d));
    else
      chk(fBits[idx] == expFrame(2, a, d), "R2 R5 fetch frame", fBits[idx], expFrame(2, a, d));
    if (kind == 2) begin
      chk(fRdV[idx] == 1'b1, "R5 rdValid at cs drop", fRdV[idx], 1);
      chk(fRd[idx] == expRd, "R5 R6 fetched byte", fRd[idx], expRd);
      chk(busyCnt[idx] == 0, "R7 no wait after fetch", busyCnt[idx], 0);
    end else begin
      chk(fBusy[idx] == 1'b1, "R7 busy at cs drop", fBusy[idx], 1);
      chk(busyCnt[idx] == WAITC, "R7 wait length", busyCnt[idx], WAITC);
    end
  endtask

  task automatic doOp(int kind, logic [6:0] a, logic [7:0] d);
    int base, nExp, ackAt;
    bit autoEn;
    base = nF;
    autoEn = (kind == 1) && !expEn;
    nExp = autoEn ? 2 : 1;
    @(negedge clk);
    addr = a; wrData = d;
    rdReq = (kind == 2); wrReq = (kind == 1); enReq = (kind == 0);
    do @(negedge clk); while (!ack);
    ackAt = nF;
    rdReq = 0; wrReq = 0; enReq = 0;
    chk(cs == 1'b0, "R10 cs still low in ack cycle", cs, 0);
    @(negedge clk);
    chk(cs == 1'b1 && ack == 1'b0, "R10 cs rises after one-cycle ack", {ack, cs}, 1);
    while (nF < base + nExp || busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(nF == base + nExp, "R8 number of frames", nF - base, nExp);
    chk(ackAt == base + nExp - 1, "R8 ack follows auto unlock", ackAt - base, nExp - 1);
    if (autoEn) begin
      checkFrame(base, 0, a, d, 8'h00);
      expEn = 1;
    end
    checkFrame(base + nExp - 1, kind, a, d, expMem[a]);
    if (kind == 1) expMem[a] = d;
    if (kind == 0) expEn = 1;
  endtask

  task automatic doPriority(logic [6:0] a, logic [7:0] d);
    int base, acks;
    logic [7:0] oldVal;
    base = nF; acks = 0; oldVal = expMem[a];
    @(negedge clk);
    addr = a; wrData = d; rdReq = 1; wrReq = 1; enReq = 1;
    while (acks < 3) begin
      @(negedge clk);
      if (ack) begin
        acks++;
        if (rdReq) rdReq = 0;
        else if (wrReq) wrReq = 0;
        else enReq = 0;
      end
    end
    while (nF < base + 3 || busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(fLen[base] == 24 && fBits[base][23:16] == 8'h03, "R9 fetch served first",
        fBits[base][23:16], 8'h03);
    checkFrame(base, 2, a, d, oldVal);
    chk(fBits[base+1][23:16] == 8'h02 && fBits[base+1][15], "R9 store served second",
        fBits[base+1][23:15], 9'h005);
    checkFrame(base + 1, 1, a, d, 8'h00);
    expMem[a] = d;
    chk(fLen[base+2] == 16, "R9 unlock served last", fLen[base+2], 16);
    checkFrame(base + 2, 0, a, d, 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    int kind;
    logic [6:0] a;
    logic [7:0] d;
    void'($urandom(32'h1a2b3c));
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(cs == 0, "R1 reset cs low", cs, 0);
    chk(sclk == 1, "R6 reset clock high", sclk, 1);
    chk(busy == 0 && ack == 0 && rdValid == 0, "R7 reset quiet", {busy, ack, rdValid}, 0);
    // directed corners
    doOp(1, 7'h7F, 8'hA5);   // first store: auto unlock (R8)
    doOp(2, 7'h7F, 8'h00);
    doOp(2, 7'h00, 8'h00);   // unwritten address
    doOp(1, 7'h00, 8'hFF);
    doOp(2, 7'h00, 8'h00);
    doOp(1, 7'h55, 8'h00);
    doOp(2, 7'h55, 8'h00);
    doOp(0, 7'h12, 8'h34);   // explicit unlock
    doPriority(7'h2A, 8'h3C);
    for (int i = 0; i < 50; i++) begin
      kind = $urandom % 3;
      a = 7'($urandom);
      d = 8'($urandom);
      doOp(kind, a, d);
    end
    doPriority(7'h01, 8'h81);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule